// File: doc/BRIEF.md
# Block-Interleaving Telemetry Multiplexer

This block merges several independent serial telemetry streams, each arriving at its own rate, into one faster serial output. Every source delivers bits with a bit input and a strobe. The block gathers each source's bits into a fixed-length block, moves each finished block into a short queue, and sends it out with a small source label in front. All logic runs on one fast system clock. The input strobes and the output enable act as bit enables on that clock.

Blocks leave in the order in which they were completed, not in a fixed rotation. This means the input and output rates need not be related. A receiver reads the label to find the source of each block. If no block is waiting when an output slot starts, the slot carries an auxiliary filler block. At a fixed period a sync block is forced into the stream. Each source has two block buffers that it uses in turn: one fills while the other waits for transfer. If a source completes a block while its previous block has still not been moved out, the new block is lost. The block records that loss in a sticky per-source flag.

Top module: `tdm_blk_mux`

## Requirements
- R1: After synchronous reset, `ser_out` is 0, all `ovf` bits are 0, and the first output slot carries an auxiliary block.
- R2: A source block is 32 bits, taken one bit for each cycle with that source's strobe high. The first strobed bit becomes the data MSB.
- R3: Each output block is 34 bits: a 2-bit label, then 32 data bits, both MSB first. One bit is emitted for each cycle with `out_en` high, and blocks follow each other with no gap. While `out_en` is low, `ser_out` holds its value.
- R4: Data blocks carry their source index (0 to 2) as the label. They leave in the order in which they were transferred, and no block is duplicated or reordered.
- R5: If no data block is queued when a slot starts, the slot carries label 3 with data `AUX_WORD` (default 32'hA5A5_0F0F).
- R6: Every 20th slot (slot indexes 19, 39, … counted from reset) carries label 3 with data `SYNC_WORD` (default 32'h1ACF_FC1D). Queued data waits for the following slot.
- R7: When several sources have a block waiting at the same time, the lowest source index is transferred first. At most one block is transferred per clock.
- R8: If a source completes a block while its other buffer is still waiting, its `ovf` bit is set and the newly completed block is discarded. The waiting block is kept and is sent later.
- R9: An `ovf` bit stays set until `ovf_clr` is high. `ovf_clr` clears all bits on the next clock and takes precedence over a new overflow in the same cycle.
- R10: The output queue holds 4 blocks. While it is full, no transfer happens and a finished block waits in its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than every bit rate |
| rst | input | 1 | Synchronous active-high reset |
| src_bit | input | NSRC | Serial data bit of each source |
| src_stb | input | NSRC | One-cycle strobe per source that accepts `src_bit` |
| out_en | input | 1 | Output bit enable; one output bit is emitted per high cycle |
| ovf_clr | input | 1 | Synchronous clear of all overflow flags |
| ser_out | output | 1 | Multiplexed serial output |
| ovf | output | NSRC | Sticky per-source overflow flags |

## Verification
Each kind of internal fault shows up in the output in its own way:
- If a ping-pong index or bit counter goes wrong, the next data block from that source carries corrupted or shifted data. This shows within one 34-bit slot after the block would normally have left.
- If the slot counter goes wrong, the sync block moves away from slot 19 of each group of twenty. This is visible before the fortieth slot.
- If the arbiter or the queue pointers go wrong, two blocks completed together come out swapped, or one block is repeated or missing. This appears in the first few slots that follow.
- If the buffer-pending state goes wrong, overflow is flagged at the wrong time, or the block that should survive an overflow does not appear once the output restarts.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
    localparam int BLK_W = 32;
    localparam int LBL_W = 2;
    localparam int WORD_W = LBL_W + BLK_W;
    localparam logic [LBL_W-1:0] AUX_LBL = '1;

    typedef struct packed {
        logic [LBL_W-1:0] lbl;
        logic [BLK_W-1:0] data;
    } blk_t;
endpackage

// File: rtl/tbm_src_collect.sv
module tbm_src_collect
    import tbm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_i,
    input  logic             stb_i,
    input  logic             take_i,
    output logic             pend_o,
    output logic [BLK_W-1:0] data_o,
    output logic             ovf_evt_o
);
    localparam int CW = $clog2(BLK_W);

    logic [1:0][BLK_W-1:0] buf_q;
    logic                  act_q;
    logic                  pend_q;
    logic [CW-1:0]         cnt_q;
    logic                  last;

    assign last      = stb_i && (cnt_q == CW'(BLK_W - 1));
    assign ovf_evt_o = last && pend_q && !take_i;
    assign pend_o    = pend_q;
    assign data_o    = buf_q[~act_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q  <= '0;
            act_q  <= 1'b0;
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (take_i)
                pend_q <= 1'b0;
            if (stb_i) begin
                buf_q[act_q] <= {buf_q[act_q][BLK_W-2:0], bit_i};
                if (last) begin
                    cnt_q <= '0;
                    if (!ovf_evt_o) begin
                        act_q  <= ~act_q;
                        pend_q <= 1'b1;
                    end
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tbm_xfer_ring.sv
module tbm_xfer_ring
    import tbm_pkg::*;
#(
    parameter int NSRC  = 3,
    parameter int DEPTH = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NSRC-1:0]                pend_i,
    input  logic [NSRC-1:0][BLK_W-1:0]     data_i,
    input  logic                           pop_i,
    output logic [NSRC-1:0]                take_o,
    output blk_t                           head_o,
    output logic                           empty_o,
    output logic [$clog2(DEPTH+1)-1:0]     cnt_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    blk_t          ring_q [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic [IW-1:0] win;
    logic          push, room;

    assign room = (cnt_q != CW'(DEPTH));

    always_comb begin
        take_o = '0;
        win    = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend_i[i]) win = IW'(i);
        end
        if (room && (|pend_i)) take_o[win] = 1'b1;
    end

    assign push    = |take_o;
    assign empty_o = (cnt_q == '0);
    assign head_o  = ring_q[rd_q];
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk) begin
        if (push)
            ring_q[wr_q] <= '{lbl: LBL_W'(win), data: data_i[win]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push)
                wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop_i)
                rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            case ({push, pop_i})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/tbm_serializer.sv
module tbm_serializer
    import tbm_pkg::*;
#(
    parameter int               SYNC_EVERY = 20,
    parameter logic [BLK_W-1:0] SYNC_WORD  = 32'h1ACF_FC1D,
    parameter logic [BLK_W-1:0] AUX_WORD   = 32'hA5A5_0F0F
) (
    input  logic clk,
    input  logic rst,
    input  logic out_en,
    input  blk_t head_i,
    input  logic empty_i,
    output logic pop_o,
    output logic ser_o
);
    localparam int BCW = $clog2(WORD_W);
    localparam int SCW = (SYNC_EVERY > 1) ? $clog2(SYNC_EVERY) : 1;

    logic [WORD_W-1:0] sh_q, word;
    logic [BCW-1:0]    bcnt_q;
    logic [SCW-1:0]    slot_q;
    logic              start, sync_slot;

    assign start     = out_en && (bcnt_q == '0);
    assign sync_slot = (slot_q == SCW'(SYNC_EVERY - 1));
    assign pop_o     = start && !sync_slot && !empty_i;

    always_comb begin
        if (sync_slot)
            word = {AUX_LBL, SYNC_WORD};
        else if (empty_i)
            word = {AUX_LBL, AUX_WORD};
        else
            word = head_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            bcnt_q <= '0;
            slot_q <= '0;
            ser_o  <= 1'b0;
        end else if (start) begin
            ser_o  <= word[WORD_W-1];
            sh_q   <= {word[WORD_W-2:0], 1'b0};
            bcnt_q <= BCW'(1);
            slot_q <= sync_slot ? '0 : slot_q + 1'b1;
        end else if (out_en) begin
            ser_o  <= sh_q[WORD_W-1];
            sh_q   <= {sh_q[WORD_W-2:0], 1'b0};
            bcnt_q <= (bcnt_q == BCW'(WORD_W - 1)) ? '0 : bcnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tdm_blk_mux.sv
module tdm_blk_mux
    import tbm_pkg::*;
#(
    parameter int               NSRC       = 3,
    parameter int               NOUT       = 4,
    parameter int               SYNC_EVERY = 20,
    parameter logic [BLK_W-1:0] SYNC_WORD  = 32'h1ACF_FC1D,
    parameter logic [BLK_W-1:0] AUX_WORD   = 32'hA5A5_0F0F
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_bit,
    input  logic [NSRC-1:0] src_stb,
    input  logic            out_en,
    input  logic            ovf_clr,
    output logic            ser_out,
    output logic [NSRC-1:0] ovf
);
    localparam int RCW = $clog2(NOUT + 1);

    logic [NSRC-1:0]            pend, take, ovf_evt;
    logic [NSRC-1:0][BLK_W-1:0] sdata;
    logic [RCW-1:0]             ring_cnt;
    blk_t                       head;
    logic                       empty, pop;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        tbm_src_collect u_col (
            .clk      (clk),
            .rst      (rst),
            .bit_i    (src_bit[g]),
            .stb_i    (src_stb[g]),
            .take_i   (take[g]),
            .pend_o   (pend[g]),
            .data_o   (sdata[g]),
            .ovf_evt_o(ovf_evt[g])
        );
    end

    tbm_xfer_ring #(.NSRC(NSRC), .DEPTH(NOUT)) u_ring (
        .clk    (clk),
        .rst    (rst),
        .pend_i (pend),
        .data_i (sdata),
        .pop_i  (pop),
        .take_o (take),
        .head_o (head),
        .empty_o(empty),
        .cnt_o  (ring_cnt)
    );

    tbm_serializer #(
        .SYNC_EVERY(SYNC_EVERY),
        .SYNC_WORD (SYNC_WORD),
        .AUX_WORD  (AUX_WORD)
    ) u_ser (
        .clk    (clk),
        .rst    (rst),
        .out_en (out_en),
        .head_i (head),
        .empty_i(empty),
        .pop_o  (pop),
        .ser_o  (ser_out)
    );

    always_ff @(posedge clk) begin
        if (rst || ovf_clr)
            ovf <= '0;
        else
            ovf <= ovf | ovf_evt;
    end
endmodule

// File: rtl/tbm_chk.sv
module tbm_chk #(
    parameter int NSRC  = 3,
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       out_en,
    input logic                       ser_out,
    input logic                       ovf_clr,
    input logic [NSRC-1:0]            ovf,
    input logic [NSRC-1:0]            ovf_evt,
    input logic [NSRC-1:0]            pend,
    input logic [NSRC-1:0]            take,
    input logic [$clog2(DEPTH+1)-1:0] ring_cnt
);
    p_ser_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !out_en |=> $stable(ser_out));

    p_take_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take));

    p_ring_bound_r10: assert property (@(posedge clk) disable iff (rst)
        ring_cnt <= ($clog2(DEPTH+1))'(DEPTH));

    p_full_no_take_r10: assert property (@(posedge clk) disable iff (rst)
        (ring_cnt == ($clog2(DEPTH+1))'(DEPTH)) |-> (take == '0));

    p_ovf_clr_r9: assert property (@(posedge clk) disable iff (rst)
        ovf_clr |=> (ovf == '0));

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        p_take_prio_r7: assert property (@(posedge clk) disable iff (rst)
            take[i] |-> ((pend & NSRC'((1 << i) - 1)) == '0));

        p_ovf_set_r8: assert property (@(posedge clk) disable iff (rst)
            (ovf_evt[i] && !ovf_clr) |=> ovf[i]);

        p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
            (ovf[i] && !ovf_clr) |=> ovf[i]);
    end
endmodule

bind tdm_blk_mux tbm_chk #(.NSRC(NSRC), .DEPTH(NOUT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .out_en  (out_en),
    .ser_out (ser_out),
    .ovf_clr (ovf_clr),
    .ovf     (ovf),
    .ovf_evt (ovf_evt),
    .pend    (pend),
    .take    (take),
    .ring_cnt(ring_cnt)
);

// File: tb/sim_tdm_blk_mux.sv
module sim_tdm_blk_mux;
    localparam int          CLK_P  = 10;
    localparam logic [31:0] SYNC_W = 32'h1ACF_FC1D;
    localparam logic [31:0] AUX_W  = 32'hA5A5_0F0F;

    // table of {source, data}; each block must emerge unchanged (R2, R4)
    localparam logic [33:0] TBL [8] = '{
        {2'd0, 32'h8000_0001}, {2'd1, 32'hFFFF_FFFF},
        {2'd2, 32'h0000_0000}, {2'd0, 32'h1234_5678},
        {2'd1, 32'hDEAD_BEEF}, {2'd2, 32'h5555_AAAA},
        {2'd2, 32'h0F0F_F0F0}, {2'd0, 32'hC001_D00D}
    };

    logic       clk = 0, rst = 1, out_en = 0, ovf_clr = 0;
    logic [2:0] src_bit = '0, src_stb = '0;
    logic       ser_out;
    logic [2:0] ovf;

    int checks = 0, errors = 0;
    logic [33:0] words [512];
    int nwords = 0, nbits = 0;
    logic [33:0] sh = '0;
    logic [33:0] expq [64];
    int nexp = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    tdm_blk_mux #(.NSRC(3), .NOUT(4), .SYNC_EVERY(20),
                  .SYNC_WORD(SYNC_W), .AUX_WORD(AUX_W)) u0 (
        .clk(clk), .rst(rst), .src_bit(src_bit), .src_stb(src_stb),
        .out_en(out_en), .ovf_clr(ovf_clr), .ser_out(ser_out), .ovf(ovf)
    );

    always @(posedge clk) begin
        #1;
        if (!rst && out_en) begin
            sh = {sh[32:0], ser_out};
            nbits++;
            if (nbits == 34) begin
                if (nwords < 512) words[nwords] = sh;
                nwords++;
                nbits = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_blk(input int s, input logic [31:0] d);
        for (int b = 31; b >= 0; b--) begin
            @(negedge clk); src_bit[s] = d[b]; src_stb[s] = 1'b1;
            @(negedge clk); src_stb[s] = 1'b0;
        end
        expq[nexp] = {2'(s), d}; nexp++;
    endtask

    task automatic send_pair(input logic [31:0] d0, input logic [31:0] d2);
        for (int b = 31; b >= 0; b--) begin
            @(negedge clk); src_bit[0] = d0[b]; src_bit[2] = d2[b]; src_stb = 3'b101;
            @(negedge clk); src_stb = '0;
        end
        expq[nexp] = {2'd0, d0}; nexp++;
        expq[nexp] = {2'd2, d2}; nexp++;
    endtask

    task automatic send_raw(input int s, input logic [31:0] d);
        for (int b = 31; b >= 0; b--) begin
            @(negedge clk); src_bit[s] = d[b]; src_stb[s] = 1'b1;
            @(negedge clk); src_stb[s] = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic held;
        int n;
        repeat (3) @(negedge clk);
        chk(ser_out == 1'b0, "R1 ser_out", 64'(ser_out), 64'h0);
        chk(ovf == 3'b000, "R1 ovf", 64'(ovf), 64'h0);
        rst = 0;
        out_en = 1;

        // table walk: sequential blocks (R2, R3, R4)
        foreach (TBL[i]) send_blk(int'(TBL[i][33:32]), TBL[i][31:0]);

        // simultaneous completion: source 0 before source 2 (R7)
        send_pair(32'h0BAD_CAFE, 32'h7777_0001);
        repeat (300) @(negedge clk);

        // output hold while disabled (R3)
        out_en = 0;
        held = ser_out;
        repeat (6) @(negedge clk);
        chk(ser_out == held, "R3 hold", 64'(ser_out), 64'(held));

        // fill the queue, then one waiting block, then overflow on source 1 (R10, R8)
        send_blk(0, 32'h0000_0010);
        send_blk(1, 32'h0000_0011);
        send_blk(2, 32'h0000_0012);
        send_blk(0, 32'h0000_0013);
        send_blk(1, 32'h0000_0014);
        repeat (3) @(negedge clk);
        chk(ovf == 3'b000, "R10 no ovf with waiting block", 64'(ovf), 64'h0);
        send_raw(1, 32'hBADB_AD00);
        repeat (3) @(negedge clk);
        chk(ovf == 3'b010, "R8 ovf set", 64'(ovf), 64'h2);
        repeat (20) @(negedge clk);
        chk(ovf == 3'b010, "R9 sticky", 64'(ovf), 64'h2);
        ovf_clr = 1;
        @(negedge clk);
        ovf_clr = 0;
        chk(ovf == 3'b000, "R9 clear", 64'(ovf), 64'h0);

        out_en = 1;
        repeat (1600) @(negedge clk);

        // analyse captured slots (R1, R4, R5, R6)
        chk(nwords >= 40, "R6 slot count", 64'(nwords), 64'd40);
        if (nwords > 0)
            chk(words[0] == {2'b11, AUX_W}, "R1 first slot aux", 64'(words[0]), 64'({2'b11, AUX_W}));
        n = 0;
        for (int k = 0; k < nwords && k < 512; k++) begin
            if (k % 20 == 19)
                chk(words[k] == {2'b11, SYNC_W}, "R6 sync slot", 64'(words[k]), 64'({2'b11, SYNC_W}));
            else if (words[k][33:32] == 2'b11)
                chk(words[k][31:0] == AUX_W, "R5 aux data", 64'(words[k]), 64'({2'b11, AUX_W}));
            else begin
                if (n < nexp)
                    chk(words[k] == expq[n], "R4 R7 block order/data", 64'(words[k]), 64'(expq[n]));
                else
                    chk(1'b0, "R4 extra block", 64'(words[k]), 64'h0);
                n++;
            end
        end
        chk(n == nexp, "R8 R4 block count", 64'(n), 64'(nexp));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule